// File: doc/BRIEF.md
# Serial NOR Flash Command Engine

This block is a byte-level slave model of a serial NOR flash device. The serial shifter in front of it delivers one strobe per completed 8-bit transfer, together with the received byte. The engine answers every strobe with one response byte two clock cycles later. A separate one-cycle pulse marks each new chip-select assertion. The engine decodes the first byte after chip select as an opcode. It then gathers any address and dummy bytes, and after that it streams array data out, programs bytes, erases regions, reports the write-enable latch or returns the identification bytes.

Storage is an on-chip byte array that powers up all ones, and its size and sector size are parameters. Erasing is a fill that runs one byte per clock. While it runs, `busy` is high and every incoming byte is discarded with a response of zero. Programming can only clear bits unless the overwrite parameter is set, and read streaming wraps at the end of the array.

Top module: `snor_flash_engine`

## Requirements
- R1: After synchronous reset, `resp_vld`, `resp_out` and `busy` are 0, the write-enable latch is clear and the array holds 0xFF in every byte.
- R2: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Opcode 0x05 is followed by one response byte that carries the latch in bit 1 and zeros in every other bit.
- R3: Opcode 0x9F is followed by the three bytes of `ID_CODE`, most significant byte first. When `EXT_ID` is nonzero, the high and then the low byte of `EXT_ID` follow. After the last of these bytes, the next byte is decoded as an opcode.
- R4: Opcode 0x03 takes three address bytes, most significant first. Each following byte returns the array byte at the current address, and the address then increments.
- R5: The read address wraps from MEM_BYTES-1 to 0.
- R6: Opcode 0x0B takes three address bytes and one dummy byte, then streams data as in R4.
- R7: Opcode 0x02 takes three address bytes. Each following byte is stored at an incrementing address as the old byte AND the new byte, or as the new byte alone when OVERWRITE is 1. This continues until the next chip-select pulse.
- R8: A program issued while the write-enable latch is clear leaves the array unchanged.
- R9: Opcode 0x20 erases a region of min(SMALL_ERASE_BYTES, MEM_BYTES) bytes and 0xD8 erases a region of min(SECTOR_BYTES, MEM_BYTES) bytes. In both cases the start is the collected address aligned down to the region size. Opcode 0xC7 erases the whole array. The erased region reads 0xFF and bytes outside it keep their values. `busy` is high for exactly as many cycles as the region has bytes.
- R10: An erase issued while the write-enable latch is clear does not raise `busy` and changes no data.
- R11: While `busy` is high, incoming bytes have no effect on the engine state or the latch, and each one still gets a response of 0x00.
- R12: A `cs_start` pulse aborts any command in progress, so the next byte is decoded as an opcode.
- R13: `resp_vld` is high for one cycle exactly two cycles after each cycle in which `byte_vld` is high. Strobes never arrive in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_start | input | 1 | One-cycle pulse at each chip-select assertion |
| byte_vld | input | 1 | Strobe: a received byte is on `byte_in` |
| byte_in | input | 8 | Received byte |
| resp_vld | output | 1 | Response byte valid |
| resp_out | output | 8 | Response byte for the strobe two cycles earlier |
| busy | output | 1 | Erase fill in progress |

## Verification
Most internal faults in this engine surface within one command at the ports. A wrong collection count or a wrong state after the last address byte shifts the data stream, so the first read or status byte comes back as a command echo of zero or as the neighbouring byte. A latch that is stuck or lost changes the status byte on its very next read. A program or erase gated wrongly is only seen on the next read of the touched address, which is why every store and erase is followed by a read-back. The erase length and alignment are checked by counting `busy` cycles and by reading bytes just inside and just outside the region.

// File: rtl/snor_pkg.sv
package snor_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_READ,
    ST_PROG,
    ST_FIXED
  } eng_state_t;

  typedef enum logic [1:0] {
    PK_NONE,
    PK_READ,
    PK_PROG,
    PK_FIXED
  } pend_kind_t;

  localparam logic [7:0] OP_NOP   = 8'h00;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDIS = 8'h04;
  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_FAST  = 8'h0B;
  localparam logic [7:0] OP_ERA_A = 8'h20;
  localparam logic [7:0] OP_IDENT = 8'h9F;
  localparam logic [7:0] OP_BULK  = 8'hC7;
  localparam logic [7:0] OP_ERA_S = 8'hD8;

endpackage

// File: rtl/snor_store.sv
module snor_store #(
  parameter int DEPTH = 4096,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/snor_reply_rom.sv
module snor_reply_rom #(
  parameter logic [23:0] ID_CODE = 24'hC2A517,
  parameter logic [15:0] EXT_ID  = 16'h0000
) (
  input  logic       sel_status,
  input  logic       wel,
  input  logic [2:0] idx,
  output logic [7:0] byte_o,
  output logic [2:0] last_o
);

  logic [2:0] id_last;

  generate
    if (EXT_ID != 16'h0000) begin : g_ext
      assign id_last = 3'd4;
    end else begin : g_base
      assign id_last = 3'd2;
    end
  endgenerate

  always_comb begin
    if (sel_status) begin
      byte_o = {6'b0, wel, 1'b0};
      last_o = 3'd0;
    end else begin
      last_o = id_last;
      case (idx)
        3'd0:    byte_o = ID_CODE[23:16];
        3'd1:    byte_o = ID_CODE[15:8];
        3'd2:    byte_o = ID_CODE[7:0];
        3'd3:    byte_o = EXT_ID[15:8];
        3'd4:    byte_o = EXT_ID[7:0];
        default: byte_o = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/snor_eraser.sv
module snor_eraser #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] last_off,
  output logic          busy,
  output logic [AW-1:0] waddr
);

  logic [AW-1:0] ptr;
  logic [AW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      ptr    <= '0;
      remain <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      ptr    <= base;
      remain <= last_off;
    end else if (busy) begin
      ptr    <= ptr + 1'b1;
      remain <= remain - 1'b1;
      if (remain == '0) busy <= 1'b0;
    end
  end

  assign waddr = ptr;

  // R11: the command side must never request a new fill during one
  p_no_restart_r11: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);

endmodule

// File: rtl/snor_cmd_fsm.sv
module snor_cmd_fsm
  import snor_pkg::*;
#(
  parameter int          MEM_BYTES         = 4096,
  parameter int          SECTOR_BYTES      = 1024,
  parameter int          SMALL_ERASE_BYTES = 4096,
  parameter logic [23:0] ID_CODE           = 24'hC2A517,
  parameter logic [15:0] EXT_ID            = 16'h0000,
  parameter int          AW                = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_start,
  input  logic          byte_vld,
  input  logic [7:0]    byte_in,
  input  logic          busy,
  output logic [AW-1:0] rd_addr,
  output logic          ers_start,
  output logic [AW-1:0] ers_base,
  output logic [AW-1:0] ers_last,
  output logic          p_vld,
  output pend_kind_t    p_kind,
  output logic [AW-1:0] p_addr,
  output logic [7:0]    p_data,
  output logic [7:0]    p_fixed,
  output logic          wel_o
);

  localparam int LEN_A = (SMALL_ERASE_BYTES < MEM_BYTES) ? SMALL_ERASE_BYTES : MEM_BYTES;
  localparam int LEN_S = (SECTOR_BYTES < MEM_BYTES) ? SECTOR_BYTES : MEM_BYTES;
  localparam logic [AW-1:0] MASK_A   = AW'(LEN_A - 1);
  localparam logic [AW-1:0] MASK_S   = AW'(LEN_S - 1);
  localparam logic [AW-1:0] MASK_ALL = AW'(MEM_BYTES - 1);

  eng_state_t    state;
  logic          wel;
  logic [2:0]    cnt;
  logic [2:0]    need;
  logic [2:0]    fix_idx;
  logic          fix_stat;
  logic [23:0]   asr;
  logic [7:0]    op;
  logic [AW-1:0] cur;

  logic          accept;
  logic          coll_done;
  logic [23:0]   next_addr;
  logic [AW-1:0] na;
  logic [7:0]    fix_byte;
  logic [2:0]    fix_last;
  logic          unused_addr_hi;

  assign accept         = byte_vld && !busy && !cs_start;
  assign next_addr      = (cnt < 3'd3) ? {asr[15:0], byte_in} : asr;
  assign na             = next_addr[AW-1:0];
  assign unused_addr_hi = ^next_addr;
  assign coll_done      = (state == ST_COLLECT) && ((cnt + 3'd1) == need);
  assign rd_addr        = cur;
  assign wel_o          = wel;

  snor_reply_rom #(
    .ID_CODE (ID_CODE),
    .EXT_ID  (EXT_ID)
  ) u_rom (
    .sel_status (fix_stat),
    .wel        (wel),
    .idx        (fix_idx),
    .byte_o     (fix_byte),
    .last_o     (fix_last)
  );

  // erase launch: whole array directly from idle, regions after the address
  always_comb begin
    ers_start = 1'b0;
    ers_base  = '0;
    ers_last  = '0;
    if (accept && wel) begin
      if (state == ST_IDLE && byte_in == OP_BULK) begin
        ers_start = 1'b1;
        ers_last  = MASK_ALL;
      end else if (coll_done && op == OP_ERA_A) begin
        ers_start = 1'b1;
        ers_base  = na & ~MASK_A;
        ers_last  = MASK_A;
      end else if (coll_done && op == OP_ERA_S) begin
        ers_start = 1'b1;
        ers_base  = na & ~MASK_S;
        ers_last  = MASK_S;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      wel      <= 1'b0;
      cnt      <= '0;
      need     <= '0;
      fix_idx  <= '0;
      fix_stat <= 1'b0;
      asr      <= '0;
      op       <= OP_NOP;
      cur      <= '0;
    end else if (cs_start) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      fix_idx <= '0;
    end else if (accept) begin
      case (state)
        ST_IDLE: begin
          op  <= byte_in;
          cnt <= '0;
          case (byte_in)
            OP_WREN:  wel <= 1'b1;
            OP_WRDIS: wel <= 1'b0;
            OP_STAT: begin
              state    <= ST_FIXED;
              fix_stat <= 1'b1;
              fix_idx  <= '0;
            end
            OP_IDENT: begin
              state    <= ST_FIXED;
              fix_stat <= 1'b0;
              fix_idx  <= '0;
            end
            OP_READ, OP_PROG, OP_ERA_A, OP_ERA_S: begin
              state <= ST_COLLECT;
              need  <= 3'd3;
            end
            OP_FAST: begin
              state <= ST_COLLECT;
              need  <= 3'd4;
            end
            default: ;
          endcase
        end
        ST_COLLECT: begin
          if (cnt < 3'd3) asr <= {asr[15:0], byte_in};
          cnt <= cnt + 3'd1;
          if (coll_done) begin
            cur <= na;
            case (op)
              OP_READ, OP_FAST: state <= ST_READ;
              OP_PROG:          state <= ST_PROG;
              default:          state <= ST_IDLE;
            endcase
          end
        end
        ST_READ, ST_PROG: cur <= cur + 1'b1;
        ST_FIXED: begin
          if (fix_idx == fix_last) begin
            state   <= ST_IDLE;
            fix_idx <= '0;
          end else begin
            fix_idx <= fix_idx + 3'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // first pipeline stage: remember what the memory result is for
  always_ff @(posedge clk) begin
    if (rst) begin
      p_vld   <= 1'b0;
      p_kind  <= PK_NONE;
      p_addr  <= '0;
      p_data  <= '0;
      p_fixed <= '0;
    end else begin
      p_vld   <= byte_vld;
      p_addr  <= cur;
      p_data  <= byte_in;
      p_fixed <= fix_byte;
      p_kind  <= PK_NONE;
      if (accept) begin
        case (state)
          ST_READ:  p_kind <= PK_READ;
          ST_PROG:  p_kind <= wel ? PK_PROG : PK_NONE;
          ST_FIXED: p_kind <= PK_FIXED;
          default:  p_kind <= PK_NONE;
        endcase
      end
    end
  end

  // R13: strobes are at least one idle cycle apart
  p_strobe_gap_r13: assert property (@(posedge clk) disable iff (rst)
    byte_vld |=> !byte_vld);

  // R12: a chip-select pulse always lands the engine in idle
  p_cs_idle_r12: assert property (@(posedge clk) disable iff (rst)
    cs_start |=> (state == ST_IDLE));

  // R4: byte collection never overruns the expected count
  p_collect_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COLLECT) |-> (cnt < need));

endmodule

// File: rtl/snor_resp_stage.sv
module snor_resp_stage
  import snor_pkg::*;
#(
  parameter bit OVERWRITE = 1'b0,
  parameter int AW        = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          p_vld,
  input  pend_kind_t    p_kind,
  input  logic [AW-1:0] p_addr,
  input  logic [7:0]    p_data,
  input  logic [7:0]    p_fixed,
  input  logic [7:0]    mem_q,
  output logic          prog_we,
  output logic [AW-1:0] prog_addr,
  output logic [7:0]    prog_wdata,
  output logic          resp_vld,
  output logic [7:0]    resp_out
);

  assign prog_we   = (p_kind == PK_PROG);
  assign prog_addr = p_addr;

  generate
    if (OVERWRITE) begin : g_over
      assign prog_wdata = p_data;
    end else begin : g_and
      assign prog_wdata = p_data & mem_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_vld <= 1'b0;
      resp_out <= 8'h00;
    end else begin
      resp_vld <= p_vld;
      case (p_kind)
        PK_READ:  resp_out <= mem_q;
        PK_FIXED: resp_out <= p_fixed;
        default:  resp_out <= 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/snor_flash_engine.sv
module snor_flash_engine
  import snor_pkg::*;
#(
  parameter int          MEM_BYTES         = 4096,
  parameter int          SECTOR_BYTES      = 1024,
  parameter int          SMALL_ERASE_BYTES = 4096,
  parameter logic [23:0] ID_CODE           = 24'hC2A517,
  parameter logic [15:0] EXT_ID            = 16'h0000,
  parameter bit          OVERWRITE         = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_start,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  output logic       resp_vld,
  output logic [7:0] resp_out,
  output logic       busy
);

  localparam int AW = $clog2(MEM_BYTES);

  logic [AW-1:0] rd_addr, ers_base, ers_last, ers_ptr;
  logic [AW-1:0] p_addr, prog_addr, mem_addr;
  logic          ers_start, ers_busy, p_vld, prog_we, mem_we, wel;
  logic [7:0]    p_data, p_fixed, prog_wdata, mem_wdata, mem_q;
  pend_kind_t    p_kind;

  snor_cmd_fsm #(
    .MEM_BYTES         (MEM_BYTES),
    .SECTOR_BYTES      (SECTOR_BYTES),
    .SMALL_ERASE_BYTES (SMALL_ERASE_BYTES),
    .ID_CODE           (ID_CODE),
    .EXT_ID            (EXT_ID),
    .AW                (AW)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cs_start  (cs_start),
    .byte_vld  (byte_vld),
    .byte_in   (byte_in),
    .busy      (ers_busy),
    .rd_addr   (rd_addr),
    .ers_start (ers_start),
    .ers_base  (ers_base),
    .ers_last  (ers_last),
    .p_vld     (p_vld),
    .p_kind    (p_kind),
    .p_addr    (p_addr),
    .p_data    (p_data),
    .p_fixed   (p_fixed),
    .wel_o     (wel)
  );

  snor_eraser #(.AW(AW)) u_ers (
    .clk      (clk),
    .rst      (rst),
    .start    (ers_start),
    .base     (ers_base),
    .last_off (ers_last),
    .busy     (ers_busy),
    .waddr    (ers_ptr)
  );

  snor_resp_stage #(.OVERWRITE(OVERWRITE), .AW(AW)) u_resp (
    .clk        (clk),
    .rst        (rst),
    .p_vld      (p_vld),
    .p_kind     (p_kind),
    .p_addr     (p_addr),
    .p_data     (p_data),
    .p_fixed    (p_fixed),
    .mem_q      (mem_q),
    .prog_we    (prog_we),
    .prog_addr  (prog_addr),
    .prog_wdata (prog_wdata),
    .resp_vld   (resp_vld),
    .resp_out   (resp_out)
  );

  // single memory port: erase fill, then program write-back, else read
  always_comb begin
    if (ers_busy) begin
      mem_we    = 1'b1;
      mem_addr  = ers_ptr;
      mem_wdata = 8'hFF;
    end else if (prog_we) begin
      mem_we    = 1'b1;
      mem_addr  = prog_addr;
      mem_wdata = prog_wdata;
    end else begin
      mem_we    = 1'b0;
      mem_addr  = rd_addr;
      mem_wdata = prog_wdata;
    end
  end

  snor_store #(.DEPTH(MEM_BYTES), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_q)
  );

  assign busy = ers_busy;

  // R13: every response is tied to a strobe two cycles earlier
  p_resp_lat_r13: assert property (@(posedge clk) disable iff (rst)
    resp_vld |-> $past(byte_vld, 2));

  // R11: bytes arriving during a fill answer zero
  p_busy_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (resp_vld && $past(ers_busy, 2)) |-> (resp_out == 8'h00));

  // R10: a fill only starts with the latch set
  p_erase_wel_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(ers_busy) |-> $past(wel));

  // R9: a fill never competes with a program write-back
  p_fill_excl_r9: assert property (@(posedge clk) disable iff (rst)
    ers_busy |-> !prog_we);

endmodule

// File: tb/sim_snor_flash_engine.sv
module sim_snor_flash_engine;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_start = 1'b0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       resp_vld;
  logic [7:0] resp_out;
  logic       busy;

  int nvec = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  snor_flash_engine #(
    .MEM_BYTES         (4096),
    .SECTOR_BYTES      (1024),
    .SMALL_ERASE_BYTES (4096),
    .ID_CODE           (24'hC2A517),
    .EXT_ID            (16'h5A3C),
    .OVERWRITE         (1'b0)
  ) u0 (
    .clk      (clk),
    .rst      (rst),
    .cs_start (cs_start),
    .byte_vld (byte_vld),
    .byte_in  (byte_in),
    .resp_vld (resp_vld),
    .resp_out (resp_out),
    .busy     (busy)
  );

  // {cs pulse first, byte sent, expected response}
  localparam int NV = 72;
  localparam logic [16:0] VEC [NV] = '{
    17'h1_0500, 17'h0_0000,                           // R2 status, latch clear
    17'h1_0600, 17'h1_0500, 17'h0_0002,               // R2 latch set
    17'h1_9F00, 17'h0_00C2, 17'h0_00A5, 17'h0_0017,   // R3 id bytes
    17'h0_005A, 17'h0_003C,                           // R3 extended id
    17'h0_0500, 17'h0_0002,                           // R3 back to opcode decode
    17'h1_0200, 17'h0_0000, 17'h0_0100, 17'h0_0000,   // R7 program 0x000100
    17'h0_A500, 17'h0_3C00,
    17'h1_0300, 17'h0_0000, 17'h0_0100, 17'h0_0000,   // R4 read 0x000100
    17'h0_00A5, 17'h0_003C, 17'h0_00FF,
    17'h1_0200, 17'h0_0000, 17'h0_0100, 17'h0_0000,   // R7 AND: A5 & F0
    17'h0_F000,
    17'h1_0B00, 17'h0_0000, 17'h0_0100, 17'h0_0000,   // R6 fast read + dummy
    17'h0_0000, 17'h0_00A0, 17'h0_003C,
    17'h1_0200, 17'h0_0000, 17'h0_0F00, 17'h0_FE00,   // R7 program near top
    17'h0_1200, 17'h0_3400,
    17'h1_0200, 17'h0_0000, 17'h0_0000, 17'h0_0000,   // R7 program 0x000000
    17'h0_7700,
    17'h1_0300, 17'h0_0000, 17'h0_0F00, 17'h0_FF00,   // R5 read wraps
    17'h0_0034, 17'h0_0077,
    17'h1_9F00, 17'h0_00C2,                           // R12 abort mid-id
    17'h1_0500, 17'h0_0002,                           // R12 opcode after cs
    17'h1_0400,                                       // R2 latch clear
    17'h1_0200, 17'h0_0000, 17'h0_0100, 17'h0_0100,   // R8 program w/o latch
    17'h0_0000,
    17'h1_0300, 17'h0_0000, 17'h0_0100, 17'h0_0100,   // R8 byte unchanged
    17'h0_003C,
    17'h1_0500, 17'h0_0000                            // R2 latch clear read
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %02h expected %02h", what, act, exp);
    end
  endtask

  task automatic pulse_cs();
    cs_start = 1'b1;
    @(negedge clk);
    cs_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] tx);
    byte_in  = tx;
    byte_vld = 1'b1;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic send(input logic [7:0] tx, input logic [7:0] exp, input string what);
    push(tx);
    chk({7'b0, resp_vld}, 8'h00, {what, " R13 early valid"});
    @(negedge clk);
    chk({7'b0, resp_vld}, 8'h01, {what, " R13 valid"});
    chk(resp_out, exp, what);
  endtask

  task automatic read_at(input logic [11:0] a, input logic [7:0] exp, input string what);
    pulse_cs();
    send(8'h03, 8'h00, what);
    send(8'h00, 8'h00, what);
    send({4'h0, a[11:8]}, 8'h00, what);
    send(a[7:0], 8'h00, what);
    send(8'h00, exp, what);
  endtask

  // issues a region erase; returns how many cycles busy stayed high
  task automatic erase_cmd(input logic [7:0] op, input logic [23:0] a, output int cyc);
    pulse_cs();
    send(op, 8'h00, "erase opcode");
    send(a[23:16], 8'h00, "erase addr");
    send(a[15:8], 8'h00, "erase addr");
    push(a[7:0]);
    cyc = 0;
    while (busy === 1'b1 && cyc < 20000) begin
      cyc++;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    int cyc;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({7'b0, resp_vld}, 8'h00, "R1 resp_vld");
    chk(resp_out, 8'h00, "R1 resp_out");
    chk({7'b0, busy}, 8'h00, "R1 busy");

    // table walk (R2 R3 R4 R5 R6 R7 R8 R12 R13)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16]) pulse_cs();
      send(VEC[i][15:8], VEC[i][7:0], $sformatf("table vector %0d", i));
    end

    // R10: erase with latch clear is rejected
    erase_cmd(8'hD8, 24'h000123, cyc);
    chk(8'(cyc), 8'h00, "R10 busy cycles without latch");
    read_at(12'h100, 8'hA0, "R10 data kept");

    // R9: sector erase aligned down to 0x000
    pulse_cs();
    send(8'h06, 8'h00, "R9 wren");
    erase_cmd(8'hD8, 24'h000123, cyc);
    chk(8'(cyc / 16), 8'd64, "R9 sector busy cycles/16");
    chk(8'(cyc % 16), 8'd0, "R9 sector busy cycles%16");
    read_at(12'h000, 8'hFF, "R9 sector start erased");
    read_at(12'h100, 8'hFF, "R9 sector inside erased");
    read_at(12'hFFE, 8'h12, "R9 outside sector kept");

    // R9: 4 KiB erase clamps to the 4 KiB array
    pulse_cs();
    send(8'h06, 8'h00, "R9 wren");
    erase_cmd(8'h20, 24'h000900, cyc);
    chk(8'(cyc / 64), 8'd64, "R9 small erase busy cycles/64");
    read_at(12'hFFF, 8'hFF, "R9 small erase top");

    // R9 bulk erase, R11 bytes ignored while busy
    pulse_cs();
    send(8'h02, 8'h00, "R7 program");
    send(8'h00, 8'h00, "R7 program");
    send(8'h00, 8'h00, "R7 program");
    send(8'h10, 8'h00, "R7 program");
    send(8'h00, 8'h00, "R7 program");
    read_at(12'h010, 8'h00, "R7 program cleared byte");
    pulse_cs();
    push(8'hC7);
    chk({7'b0, busy}, 8'h01, "R9 bulk busy raised");
    repeat (10) @(negedge clk);
    send(8'h04, 8'h00, "R11 byte during busy");
    chk({7'b0, busy}, 8'h01, "R11 still busy");
    cyc = 0;
    while (busy === 1'b1 && cyc < 20000) begin
      cyc++;
      @(negedge clk);
    end
    pulse_cs();
    send(8'h05, 8'h00, "R11 status opcode");
    send(8'h00, 8'h02, "R11 latch survived busy byte");
    read_at(12'h010, 8'hFF, "R9 bulk erased");
    read_at(12'hFFE, 8'hFF, "R9 bulk erased top");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule